// File: doc/BRIEF.md
# Two-Tap Pre-emphasis Serializer with Segmented Drive Control

This block turns 16-bit parallel words into a serial bit stream and, for every serial bit, works out how the four segments of a voltage-mode output driver are set. The segments carry binary weights 1, 2, 4 and 8. A segment always drives the line: it pulls up or it pulls down. The total output conductance therefore stays the same whatever emphasis is chosen. Each segment follows one of two signals. It follows the current bit, or the complement of the bit sent one bit time earlier. A 4-bit coefficient makes this choice per segment. The weighted sum of segments that pull up gives one of 16 line levels, which forms a two-tap high-pass filter.

Serialization runs on the bit clock. A 4-bit phase counter steers a binary tree of 2:1 selectors, and each counter bit toggles at half the rate of the bit below it. The block asks for a new word and a new coefficient once every 16 bit times and flags that cycle on `word_take`. In receive mode the block switches on every pull-up and every pull-down at half strength, so the pin presents a termination biased at mid-swing.

Top module: `preemph_serializer`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, `pu_en` is 0, `pd_en` is all ones and `half_drive` is 0. `word_take` is 1 in that first cycle.
- R2: `word_take` is high for exactly one cycle in every 16. `din` and `coef` are captured at the rising edge that ends a cycle with `word_take` high.
- R3: Bit 0 of a captured word is sent first and bit 15 last. Bit i appears on the drive outputs from the (i+2)-th rising edge, counting the edge that captured the word as the first.
- R4: With coefficient 0, every segment follows the current bit. `pu_en` is all ones for a 1 and all zeros for a 0.
- R5: In transmit mode, segment k has `pu_en[k]` = NOT previous bit when coefficient bit k is 1, and `pu_en[k]` = current bit when it is 0. `pd_en` is the bitwise complement of `pu_en`. Bit k has weight 2^k.
- R6: The previous bit of bit 0 is bit 15 of the word before it. For the first word after reset the previous bit is 0.
- R7: A change on `coef` between two capture edges has no effect on the word being sent. It takes effect with the next captured word.
- R8: When `rx_mode` is sampled high at a rising edge, the outputs from that edge are `pu_en` all ones, `pd_en` all ones and `half_drive` 1. The serial position keeps advancing during receive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 16 | Parallel word, sampled when `word_take` is high |
| coef | input | 4 | Emphasis coefficient, one bit per segment, sampled with `din` |
| rx_mode | input | 1 | High selects receive termination |
| word_take | output | 1 | High in the cycle whose closing edge captures `din` and `coef` |
| pu_en | output | 4 | Per-segment pull-up enable, bit k has weight 2^k |
| pd_en | output | 4 | Per-segment pull-down enable |
| half_drive | output | 1 | Both paths on at half strength (receive termination) |

## Verification
A wrong phase count shows at the ports in two ways: `word_take` falls off its 16-cycle cadence, and the bit order rotates. Either is visible within one word. A wrong previous-bit register shows on the very next bit in any segment whose coefficient bit is set. This is most direct on the first bit after reset and across word boundaries. A coefficient that is latched at the wrong moment shows within a word as a change in the segment pattern before the next capture edge. Every output bit is compared in the cycle it appears, so a fault is reported in the bit time it first affects.

// File: rtl/preemph_pkg.sv
`timescale 1ns/1ps
// Package preemph_pkg
// Shared constants and types for the pre-emphasis serializer.
// Assumes the word width is a power of two.
package preemph_pkg;
    localparam int unsigned WORD_W_DEF = 16;
    localparam int unsigned SEG_N_DEF  = 4;

    // Drive mode that the segment stage applies.
    typedef enum logic {
        DRV_TX = 1'b0,
        DRV_RX = 1'b1
    } drv_mode_e;
endpackage

// File: rtl/preemph_word_ctl.sv
`timescale 1ns/1ps
// Module preemph_word_ctl
// Bit-phase counter and word/coefficient holding registers. The counter bits
// are the select lines of the mux tree; bit l toggles at half the rate of bit l-1.
// Assumes WORD_W is a power of two. Synchronous active-low reset.
module preemph_word_ctl #(
    parameter int unsigned WORD_W = preemph_pkg::WORD_W_DEF,
    parameter int unsigned SEG_N  = preemph_pkg::SEG_N_DEF,
    localparam int unsigned CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] din,
    input  logic [SEG_N-1:0]  coef,
    output logic              load,
    output logic              run,
    output logic [CNT_W-1:0]  phase,
    output logic [WORD_W-1:0] word_q,
    output logic [SEG_N-1:0]  coef_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    // A new word is due before the first bit and after the last bit of each word.
    assign load = !run || (phase == LAST);

    // Advance the bit phase and capture word and coefficient at the word boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            phase  <= LAST;
            word_q <= '0;
            coef_q <= '0;
        end else begin
            if (load) begin
                word_q <= din;
                coef_q <= coef;
            end
            run   <= 1'b1;
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/preemph_mux_tree.sv
`timescale 1ns/1ps
// Module preemph_mux_tree
// Binary tree of 2:1 selectors that picks bit [sel] of the word. Level l is
// steered by sel[l]. Nodes are packed level by level into one flat vector.
// Assumes WORD_W is a power of two.
module preemph_mux_tree #(
    parameter int unsigned WORD_W = preemph_pkg::WORD_W_DEF,
    localparam int unsigned CNT_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  sel,
    output logic              bit_o
);
    localparam int unsigned NODES = 2 * WORD_W - 1;

    logic [NODES-1:0] node;

    // The leaves are the word bits.
    assign node[WORD_W-1:0] = word;

    for (genvar l = 0; l < CNT_W; l++) begin : g_level
        localparam int unsigned OFF_IN  = 2 * WORD_W - 2 * (WORD_W >> l);
        localparam int unsigned OFF_OUT = 2 * WORD_W - 2 * (WORD_W >> (l + 1));
        for (genvar i = 0; i < (WORD_W >> (l + 1)); i++) begin : g_mux
            // One 2:1 selector of this level.
            assign node[OFF_OUT + i] = sel[l] ? node[OFF_IN + 2*i + 1]
                                              : node[OFF_IN + 2*i];
        end
    end

    assign bit_o = node[NODES-1];
endmodule

// File: rtl/preemph_seg_select.sv
`timescale 1ns/1ps
// Module preemph_seg_select
// Holds the previous serial bit and registers the segment enables. Segments
// with a coefficient bit set follow the complement of the previous bit, and the
// rest follow the current bit. Receive mode turns on both paths at half strength.
// Assumes updates only when run is high. Synchronous active-low reset.
module preemph_seg_select #(
    parameter int unsigned SEG_N = preemph_pkg::SEG_N_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cur_bit,
    input  logic [SEG_N-1:0] coef_q,
    input  logic             rx_mode,
    output logic [SEG_N-1:0] pu_q,
    output logic [SEG_N-1:0] pd_q,
    output logic             half_q
);
    import preemph_pkg::*;

    logic             prev_bit;
    logic [SEG_N-1:0] pu_next;
    drv_mode_e        mode;

    assign mode = rx_mode ? DRV_RX : DRV_TX;

    for (genvar k = 0; k < SEG_N; k++) begin : g_seg
        // Per-segment source choice: delayed inverted tap or main tap.
        assign pu_next[k] = coef_q[k] ? ~prev_bit : cur_bit;
    end

    // Register the delay tap and the driver enables once per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_bit <= 1'b0;
            pu_q     <= '0;
            pd_q     <= '1;
            half_q   <= 1'b0;
        end else if (run) begin
            prev_bit <= cur_bit;
            if (mode == DRV_RX) begin
                pu_q   <= '1;
                pd_q   <= '1;
                half_q <= 1'b1;
            end else begin
                pu_q   <= pu_next;
                pd_q   <= ~pu_next;
                half_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/preemph_serializer.sv
`timescale 1ns/1ps
// Module preemph_serializer
// Top level: a 16:1 tree serializer followed by two-tap segment selection for a
// segmented voltage-mode driver. One serial bit per clk. Assumes din and coef
// are valid in the cycle that word_take is high. Synchronous active-low reset.
module preemph_serializer #(
    parameter int unsigned WORD_W = preemph_pkg::WORD_W_DEF,
    parameter int unsigned SEG_N  = preemph_pkg::SEG_N_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] din,
    input  logic [SEG_N-1:0]  coef,
    input  logic              rx_mode,
    output logic              word_take,
    output logic [SEG_N-1:0]  pu_en,
    output logic [SEG_N-1:0]  pd_en,
    output logic              half_drive
);
    localparam int unsigned CNT_W = $clog2(WORD_W);

    logic              load;
    logic              run;
    logic [CNT_W-1:0]  phase;
    logic [WORD_W-1:0] word_q;
    logic [SEG_N-1:0]  coef_q;
    logic              cur_bit;

    preemph_word_ctl #(.WORD_W(WORD_W), .SEG_N(SEG_N)) i_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (din),
        .coef   (coef),
        .load   (load),
        .run    (run),
        .phase  (phase),
        .word_q (word_q),
        .coef_q (coef_q)
    );

    preemph_mux_tree #(.WORD_W(WORD_W)) i_tree (
        .word  (word_q),
        .sel   (phase),
        .bit_o (cur_bit)
    );

    preemph_seg_select #(.SEG_N(SEG_N)) i_seg (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .cur_bit (cur_bit),
        .coef_q  (coef_q),
        .rx_mode (rx_mode),
        .pu_q    (pu_en),
        .pd_q    (pd_en),
        .half_q  (half_drive)
    );

    assign word_take = load;
endmodule

// File: rtl/preemph_serializer_chk.sv
`timescale 1ns/1ps
// Module preemph_serializer_chk
// Property checker bound to preemph_serializer: word cadence, reset state,
// drive consistency and receive termination.
module preemph_serializer_chk #(
    parameter int unsigned WORD_W = preemph_pkg::WORD_W_DEF,
    parameter int unsigned SEG_N  = preemph_pkg::SEG_N_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             rx_mode,
    input logic             word_take,
    input logic [SEG_N-1:0] pu_en,
    input logic [SEG_N-1:0] pd_en,
    input logic             half_drive
);
    localparam int unsigned GAP_W = $clog2(WORD_W) + 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(WORD_W - 1);

    logic             seen;
    logic [GAP_W-1:0] gap;

    // Count the cycles since the last word_take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
            gap  <= '0;
        end else if (word_take) begin
            seen <= 1'b1;
            gap  <= '0;
        end else begin
            gap  <= gap + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pu_en == '0 && pd_en == '1 && !half_drive && word_take));

    assert_take_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && gap != GAP_LAST) |-> !word_take);

    assert_take_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && gap == GAP_LAST) |-> word_take);

    assert_one_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !half_drive |-> (pd_en == ~pu_en));

    assert_rx_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run) && $past(rx_mode))
            |-> (pu_en == '1 && pd_en == '1 && half_drive));
endmodule

bind preemph_serializer preemph_serializer_chk #(.WORD_W(WORD_W), .SEG_N(SEG_N)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .rx_mode    (rx_mode),
    .word_take  (word_take),
    .pu_en      (pu_en),
    .pd_en      (pd_en),
    .half_drive (half_drive)
);

// File: tb/test_preemph_serializer.sv
`timescale 1ns/1ps
// Directed bench for preemph_serializer. Inputs change and outputs are sampled
// on the falling edge of clk.
module test_preemph_serializer;
    localparam int W = 16;
    localparam int S = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din = '0;
    logic [S-1:0] coef = '0;
    logic         rx_mode = 1'b0;
    logic         word_take;
    logic [S-1:0] pu_en;
    logic [S-1:0] pd_en;
    logic         half_drive;

    int n_chk = 0;
    int n_bad = 0;

    // Model state: previous bit and the outputs expected after the next edge.
    logic         prev_m = 1'b0;
    logic [S-1:0] pend_pu = '0;
    logic [S-1:0] pend_pd = '1;
    logic         pend_half = 1'b0;

    preemph_serializer #(.WORD_W(W), .SEG_N(S)) i_preemph_serializer (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .coef       (coef),
        .rx_mode    (rx_mode),
        .word_take  (word_take),
        .pu_en      (pu_en),
        .pd_en      (pd_en),
        .half_drive (half_drive)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // R1: reset, then check the idle drive and the first word request.
    task automatic do_reset();
        rst_n = 1'b0; din = '0; coef = '0; rx_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "drive in reset", {pu_en, pd_en, half_drive}, {4'h0, 4'hF, 1'b0});
        rst_n = 1'b1;
        prev_m = 1'b0; pend_pu = '0; pend_pd = '1; pend_half = 1'b0;
        chk("R1", "drive after release", {pu_en, pd_en, half_drive}, {4'h0, 4'hF, 1'b0});
        chk("R1", "first word_take", word_take, 1);
    endtask

    // Send one word. Starts at the falling edge of a word_take cycle.
    task automatic run_word(input logic [W-1:0] w, input logic [S-1:0] c,
                            input logic [S-1:0] c_late, input int late_at,
                            input logic [W-1:0] rx_mask, input string tag);
        chk("R2", "word_take at boundary", word_take, 1);
        din = w;
        coef = c;
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            chk(tag, $sformatf("drive {pu,pd,half} before bit %0d", i),
                {pu_en, pd_en, half_drive}, {pend_pu, pend_pd, pend_half});
            chk("R2", $sformatf("word_take at phase %0d", i), word_take, (i == W - 1));
            din = ~w;
            if (i == late_at) coef = c_late;
            rx_mode = rx_mask[i];
            if (rx_mask[i]) begin
                pend_pu = '1; pend_pd = '1; pend_half = 1'b1;
            end else begin
                for (int k = 0; k < S; k++)
                    pend_pu[k] = c[k] ? ~prev_m : w[i];
                pend_pd = ~pend_pu;
                pend_half = 1'b0;
            end
            prev_m = w[i];
        end
    endtask

    // Check the result of the last bit of the final word.
    task automatic flush(input string tag);
        @(negedge clk);
        chk(tag, "drive of last bit", {pu_en, pd_en, half_drive}, {pend_pu, pend_pd, pend_half});
    endtask

    // R6: the previous bit is 0 after reset and carries across words.
    task automatic test_prev_tap();
        run_word(16'h0001, 4'hF, 4'hF, -1, 16'h0000, "R6");
        run_word(16'hFFFF, 4'hF, 4'hF, -1, 16'h0000, "R6");
        run_word(16'h8000, 4'hF, 4'hF, -1, 16'h0000, "R6");
    endtask

    // R3/R4: bit order with no emphasis.
    task automatic test_order();
        run_word(16'hA5C3, 4'h0, 4'h0, -1, 16'h0000, "R3");
        run_word(16'h0001, 4'h0, 4'h0, -1, 16'h0000, "R3");
        run_word(16'h5A0F, 4'h0, 4'h0, -1, 16'h0000, "R4");
        run_word(16'h0000, 4'h0, 4'h0, -1, 16'h0000, "R4");
    endtask

    // R5: distinct per-segment selections.
    task automatic test_segments();
        run_word(16'h3C96, 4'h5, 4'h5, -1, 16'h0000, "R5");
        run_word(16'hC369, 4'hA, 4'hA, -1, 16'h0000, "R5");
        run_word(16'h6E21, 4'h3, 4'h3, -1, 16'h0000, "R5");
        run_word(16'h9D7B, 4'h8, 4'h8, -1, 16'h0000, "R5");
    endtask

    // R7: a coefficient change inside a word is ignored until the next word.
    task automatic test_late_coef();
        run_word(16'hB4E1, 4'h8, 4'h7, 3, 16'h0000, "R7");
        run_word(16'h4B1E, 4'h1, 4'hE, 0, 16'h0000, "R7");
    endtask

    // R8: receive termination mid-word, and the serial position keeps going.
    task automatic test_rx();
        run_word(16'hF0CC, 4'h6, 4'h6, -1, 16'h03F0, "R8");
        run_word(16'h1234, 4'h0, 4'h0, -1, 16'hFFFF, "R8");
        run_word(16'hE7A5, 4'h9, 4'h9, -1, 16'h8001, "R8");
    endtask

    initial begin
        do_reset();
        test_prev_tap();
        test_order();
        test_segments();
        test_late_coef();
        test_rx();
        flush("R8");
        do_reset();
        run_word(16'h0001, 4'hC, 4'hC, -1, 16'h0000, "R6");
        flush("R6");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        n_bad++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule